// File: doc/BRIEF.md
# Packet-Locked Polling Output Arbiter

This block decides which of four input ports may drive one router output. Each input port raises its request line while it holds a packet for this output. The arbiter polls the requests in a rotating order. It picks one requester and then stays locked on it until that packet has gone through. While it is locked, the chosen port's crossbar enable does not pulse once. It tracks, cycle by cycle, the write acknowledge that the downstream link returns for that port. A transfer therefore pauses whenever the link stalls and continues when the link accepts data again.

Internally the arbiter has eight states: a polling state and a held state for each requester. The end-of-packet input marks the cycle in which the last word of the granted packet is transferred. After that cycle the arbiter returns to polling, starting from the requester after the one it just served. The same happens when the granted port withdraws its request. The lines in this design are plain control pins rather than a valid/ready stream. The write acknowledge already acts as back-pressure: an enable is high only in cycles in which the downstream link accepts a word.

Top module: `pkt_lock_arbiter`

## Requirements
- R1: While the arbiter is polling, all enables are low. A requester found in a polling cycle is held from the next cycle on.
- R2: Polling picks the first asserted request at or after the current poll position, counting upward by index and wrapping from 3 to 0. Bit k of req_i belongs to requester k.
- R3: While requester k is held, en_o bits other than k stay low, whatever the other requests and acknowledges are.
- R4: While requester k is held and its request is high, en_o[k] equals ack_i[k] in the same cycle.
- R5: With no request asserted, the arbiter stays at its poll position and all enables stay low. eop_i is ignored while polling.
- R6: After reset the arbiter is polling at requester 0 and all enables are low.
- R7: A held requester keeps the grant until eop_i is seen while it is held. New requests from other ports do not take the grant away.
- R8: After the eop_i cycle of requester k, polling resumes at requester (k+1) mod 4. Every asserting requester is therefore served in turn.
- R9: If the held requester drops its request, its enable goes low in that same cycle. The arbiter then polls from (k+1) mod 4 in the next cycle.
- R10: At most one enable bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| req_i | input | 4 | Request per input port; bit k is requester k |
| ack_i | input | 4 | Downstream write acknowledge per requester |
| eop_i | input | 1 | Last word of the held packet is transferred this cycle |
| en_o | output | 4 | Crossbar enable per requester, at most one high |

## Verification
The hardest situation to reach is a poll position other than 0 combined with a request pattern in which the lowest-index requester is asserted but must lose. Only a completed or abandoned packet moves the poll position. The stimulus therefore chains packets back to back. It releases requester 1 with all four requests raised, so that requester 0 has to wait behind 2 and 3. It then releases requester 3 so that the position wraps. A later drop of a held request, and a pattern with gaps (only requester 3 asserted after requester 1 is served), exercise the skipping and the abandon path.

// File: rtl/parb_pkg.sv
package parb_pkg;

  typedef enum logic {
    PH_POLL = 1'b0,
    PH_HELD = 1'b1
  } parb_phase_e;

  // Next poll position after index cur among n requesters.
  function automatic int parb_next(input int cur, input int n);
    return (cur >= n - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/parb_pick.sv
// Rotating first-one search: the first asserted request at or after base_i.
module parb_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] base_i,
  output logic          found_o,
  output logic [IW-1:0] win_o
);

  // Requests rotated so that position 0 is the current poll base.
  logic [N-1:0] rot;

  always_comb begin
    for (int o = 0; o < N; o++) begin
      rot[o] = req_i[(int'(base_i) + o) % N];
    end
  end

  always_comb begin
    found_o = |rot;
    win_o   = base_i;
    for (int o = N - 1; o >= 0; o--) begin
      if (rot[o]) begin
        win_o = IW'((int'(base_i) + o) % N);
      end
    end
  end

endmodule

// File: rtl/parb_fsm.sv
// Phase and index register: (poll, k) or (held, k), i.e. 2*N states.
module parb_fsm
  import parb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          eop_i,
  input  logic          found_i,
  input  logic [IW-1:0] win_i,
  output parb_phase_e   phase_o,
  output logic [IW-1:0] idx_o
);

  parb_phase_e   phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          owner_req;

  assign owner_req = req_i[idx_q];

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    unique case (phase_q)
      PH_POLL: begin
        if (found_i) begin
          phase_d = PH_HELD;
          idx_d   = win_i;
        end
      end
      PH_HELD: begin
        if (eop_i || !owner_req) begin
          phase_d = PH_POLL;
          idx_d   = IW'(parb_next(int'(idx_q), N));
        end
      end
      default: begin
        phase_d = PH_POLL;
        idx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      phase_q <= PH_POLL;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;

endmodule

// File: rtl/parb_steer.sv
// Per-lane enable: the held owner's enable tracks its write acknowledge.
module parb_steer
  import parb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  parb_phase_e   phase_i,
  input  logic [IW-1:0] idx_i,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  ack_i,
  output logic [N-1:0]  en_o
);

  for (genvar k = 0; k < N; k++) begin : g_lane
    localparam logic [IW-1:0] LANE = IW'(k);
    logic mine;
    assign mine    = (phase_i == PH_HELD) && (idx_i == LANE);
    assign en_o[k] = mine && req_i[k] && ack_i[k];
  end

endmodule

// File: rtl/pkt_lock_arbiter.sv
module pkt_lock_arbiter
  import parb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] ack_i,
  input  logic         eop_i,
  output logic [N-1:0] en_o
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  parb_phase_e   phase;
  logic [IW-1:0] idx;
  logic          found;
  logic [IW-1:0] win;

  parb_pick #(.N(N), .IW(IW)) u_pick (
    .req_i   (req_i),
    .base_i  (idx),
    .found_o (found),
    .win_o   (win)
  );

  parb_fsm #(.N(N), .IW(IW)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .eop_i   (eop_i),
    .found_i (found),
    .win_i   (win),
    .phase_o (phase),
    .idx_o   (idx)
  );

  parb_steer #(.N(N), .IW(IW)) u_steer (
    .phase_i (phase),
    .idx_i   (idx),
    .req_i   (req_i),
    .ack_i   (ack_i),
    .en_o    (en_o)
  );

endmodule

// File: rtl/parb_chk.sv
module parb_chk
  import parb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  req_i,
  input logic [N-1:0]  ack_i,
  input logic          eop_i,
  input logic [N-1:0]  en_o,
  input parb_phase_e   phase_i,
  input logic [IW-1:0] idx_i
);

  logic          held;
  logic [IW-1:0] nxt;
  assign held = (phase_i == PH_HELD);
  assign nxt  = IW'(parb_next(int'(idx_i), N));

  // R10
  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en_o));

  // R1
  p_poll_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !held |-> en_o == '0);

  // R4 / R9: an enable needs both its request and its acknowledge
  p_en_needs_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o & ~(req_i & ack_i)) == '0);

  // R6
  p_reset_state_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!held && idx_i == '0));

  // R7
  p_hold_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && !eop_i && req_i[idx_i]) |=> (held && $stable(idx_i)));

  // R8
  p_release_next_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && (eop_i || !req_i[idx_i])) |=> (!held && idx_i == $past(nxt)));

  // R5
  p_idle_stay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held && req_i == '0) |=> (!held && $stable(idx_i)));

endmodule

bind pkt_lock_arbiter parb_chk #(.N(N)) u_parb_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .ack_i   (ack_i),
  .eop_i   (eop_i),
  .en_o    (en_o),
  .phase_i (phase),
  .idx_i   (idx)
);

// File: tb/test_pkt_lock_arbiter.sv
`timescale 1ns/1ps
module test_pkt_lock_arbiter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] ack = '0;
  logic       eop = 1'b0;
  logic [3:0] en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  pkt_lock_arbiter #(.N(4)) i_pkt_lock_arbiter (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req),
    .ack_i  (ack),
    .eop_i  (eop),
    .en_o   (en)
  );

  // Driver: apply one cycle of stimulus, queue the enable expected in it.
  task automatic step(input logic [3:0] r, input logic [3:0] a, input logic e,
                      input logic [3:0] x, input string tag);
    @(negedge clk);
    req = r;
    ack = a;
    eop = e;
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare a quarter period after the driver, away from both edges.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (exp_q.size() > 0) begin
        logic [3:0] x;
        string t;
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (en !== x) begin
          errors++;
          $display("FAIL %s: en=%b expected %b", t, en, x);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(4'b1111, 4'b1111, 1'b1, 4'b0000, "R6 during reset");
    step(4'b0000, 4'b1111, 1'b0, 4'b0000, "R6 during reset idle");
    @(negedge clk);
    rst_n = 1'b1;
    step(4'b0000, 4'b1111, 1'b0, 4'b0000, "R6 after reset");
    step(4'b0000, 4'b1111, 1'b1, 4'b0000, "R5 idle eop ignored");
    step(4'b0110, 4'b1111, 1'b0, 4'b0000, "R1 poll cycle quiet");
    step(4'b0110, 4'b1111, 1'b0, 4'b0010, "R2 req1 wins from pos0");
    step(4'b0110, 4'b1101, 1'b0, 4'b0000, "R4 ack low stalls");
    step(4'b0110, 4'b1111, 1'b0, 4'b0010, "R4 ack back");
    step(4'b0111, 4'b1111, 1'b0, 4'b0010, "R7 no preempt by req0");
    step(4'b0111, 4'b1110, 1'b1, 4'b0010, "R3 others stay low at eop");
    step(4'b0111, 4'b1111, 1'b0, 4'b0000, "R8 poll after eop");
    step(4'b0111, 4'b1111, 1'b0, 4'b0100, "R8 req2 served before req0");
    step(4'b1111, 4'b1111, 1'b1, 4'b0100, "R7 held through eop cycle");
    step(4'b1111, 4'b1111, 1'b0, 4'b0000, "R8 poll");
    step(4'b1111, 4'b1111, 1'b1, 4'b1000, "R8 req3 next");
    step(4'b1111, 4'b1111, 1'b0, 4'b0000, "R8 poll wrap");
    step(4'b1111, 4'b1111, 1'b0, 4'b0001, "R8 wrap to req0");
    step(4'b1110, 4'b1111, 1'b0, 4'b0000, "R9 drop clears enable");
    step(4'b1110, 4'b1111, 1'b0, 4'b0000, "R9 poll after drop");
    step(4'b1110, 4'b1111, 1'b1, 4'b0010, "R9 req1 next after drop");
    step(4'b1000, 4'b1111, 1'b0, 4'b0000, "R2 poll skip");
    step(4'b1000, 4'b1111, 1'b0, 4'b1000, "R2 req3 skipping empty req2");
    step(4'b0000, 4'b1111, 1'b0, 4'b0000, "R9 drop req3");
    step(4'b0000, 4'b1111, 1'b1, 4'b0000, "R5 idle stays low");
    step(4'b0000, 4'b1111, 1'b0, 4'b0000, "R5 idle");
    step(4'b0001, 4'b0000, 1'b0, 4'b0000, "R1 poll req0");
    step(4'b0001, 4'b0000, 1'b0, 4'b0000, "R4 held no ack");
    step(4'b0001, 4'b0001, 1'b1, 4'b0001, "R4 held ack at eop");
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule